// File: doc/BRIEF.md
# Prescaled Threshold Timer with Interrupt

This block is a 32-bit up-counting timer on a small memory-mapped register bus with one-cycle word read and write strobes. A free-running clock divider produces a one-cycle tick, and the count register advances by one on each tick. The divide ratio is one of eight powers of two that are not evenly spaced. When a tick arrives while the count equals the programmed threshold, the count wraps to zero and a sticky pending flag is raised. The flag also drives a level interrupt line.

Software programs the threshold while the timer is stopped. It then sets the run bit together with a divider selection, and later clears the pending flag by writing a one to a self-clearing action bit in the control word. Stopping the timer zeroes both the count and the divider, so every run starts from a known phase.

Top module: `match_timer`

## Requirements
- R1: After a synchronous active-low reset, the control, threshold and count registers read 0 and the interrupt output is 0.
- R2: While the run bit (control bit 0) is 0, the count reads 0 and does not advance. Clearing the run bit resets both the count and the divider, so after the timer is enabled again the first increment arrives exactly one full divide period later.
- R3: Control bits 3:1 select the divide ratio: 0 gives /2, 1 gives /4, 2 gives /8, 3 gives /64, 4 gives /128, 5 gives /1024, 6 gives /2048 and 7 gives /4096. With ratio N, the count register (offset 0x8) reads floor(m/N) modulo (threshold+1) m cycles after the enabling write.
- R4: Each tick increments the count by one. On a tick where the count equals the threshold (offset 0x4), the count returns to 0 instead.
- R5: The tick that wraps the count sets the pending flag. The flag reads at control bit 31, and the irq output equals it in every cycle.
- R6: Writing the control word with bit 30 set clears the pending flag. Writing with bit 30 at 0 leaves the flag unchanged, and bit 30 always reads back as 0.
- R7: If a clear write and a wrapping tick fall on the same clock edge, the pending flag ends up set.
- R8: The threshold reads back as written, including 0xFFFF_FFFF. Control bits 3:1 and 0 read back as written. Writes to the count register have no effect, and reads of any other offset return 0.
- R9: With a threshold of 0, the count stays at 0 and the pending flag is set on the first tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per word written |
| bus_rd | input | 1 | Read strobe; bus_rdata is 0 when it is low |
| bus_addr | input | 4 | Byte offset: 0x0 control, 0x4 threshold, 0x8 count |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| irq | output | 1 | Level interrupt, equal to the pending flag |

## Verification
The hardest case to reach is a clear write that lands on the same edge as a wrapping tick. The bench reaches it by counting cycles from the enabling write with the /2 divider and a threshold of 1, which puts the wraps at a fixed period of four cycles. It then issues the clear write so that the write's edge is the second wrap. The bench also steps through all eight divider settings, and through several small thresholds at /2, comparing the count and the interrupt against floor(m/N) modulo (T+1) in every cycle.

// File: rtl/match_timer_pkg.sv
// Package: shared constants and the divider-selection decode for match_timer.
// Assumes byte offsets on a 4-bit address and a 32-bit data word.
package match_timer_pkg;
    localparam int unsigned TMR_W      = 32;
    localparam int unsigned SEL_W      = 3;
    localparam int unsigned SHIFT_W    = 4;
    localparam int unsigned DIV_W      = 12;   // widest divide is 2**12
    localparam int unsigned OFS_CTRL   = 'h0;
    localparam int unsigned OFS_THR    = 'h4;
    localparam int unsigned OFS_COUNT  = 'h8;
    localparam int unsigned BIT_RUN    = 0;
    localparam int unsigned BIT_SEL_LO = 1;
    localparam int unsigned BIT_CLR    = 30;
    localparam int unsigned BIT_PEND   = 31;

    // Map a divider selection to log2 of its ratio (irregular spacing).
    function automatic logic [SHIFT_W-1:0] sel_to_shift(input logic [SEL_W-1:0] sel);
        logic [SHIFT_W-1:0] sh;
        case (sel)
            3'd0:    sh = 4'd1;
            3'd1:    sh = 4'd2;
            3'd2:    sh = 4'd3;
            3'd3:    sh = 4'd6;
            3'd4:    sh = 4'd7;
            3'd5:    sh = 4'd10;
            3'd6:    sh = 4'd11;
            default: sh = 4'd12;
        endcase
        return sh;
    endfunction
endpackage

// File: rtl/match_timer_prescaler.sv
// Module: free-running clock divider that emits a one-cycle tick every 2**shift cycles.
// Assumes: the divider restarts from 0 whenever run is low; a change of selection
// mid-count takes effect at once (the counter wraps at the first limit it reaches).
module match_timer_prescaler
    import match_timer_pkg::*;
#(
    parameter int unsigned P_SEL_W = SEL_W,
    parameter int unsigned P_DIV_W = DIV_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run_i,
    input  logic [P_SEL_W-1:0] sel_i,
    output logic               tick_o
);
    localparam int unsigned LIM_W = P_DIV_W + 1;

    logic [P_DIV_W-1:0] div_q;
    logic [LIM_W-1:0]   ratio;
    logic [P_DIV_W-1:0] lim;

    // Derive the terminal value of the divider from the selection.
    always_comb begin
        ratio  = LIM_W'(1) << sel_to_shift(SEL_W'(sel_i));
        lim    = P_DIV_W'(ratio - LIM_W'(1));
        tick_o = run_i && (div_q >= lim);
    end

    // Advance the divider while running; restart it on a tick or when stopped.
    always_ff @(posedge clk) begin
        if (!rst_n)                div_q <= '0;
        else if (!run_i || tick_o) div_q <= '0;
        else                       div_q <= div_q + P_DIV_W'(1);
    end

    // R3: the smallest ratio is 2, so two ticks never come back to back.
    assert_tick_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);

    // R2: a stopped divider never ticks in the cycle after it is stopped.
    assert_stopped_no_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> (div_q == '0));
endmodule

// File: rtl/match_timer_counter.sv
// Module: threshold counter with a sticky pending flag.
// Assumes: tick_i is a one-cycle enable from the divider; clr_i is a one-cycle
// action from the register block. A set wins over a clear on the same edge.
module match_timer_counter
    import match_timer_pkg::*;
#(
    parameter int unsigned P_W = TMR_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           run_i,
    input  logic           tick_i,
    input  logic [P_W-1:0] thr_i,
    input  logic           clr_i,
    output logic [P_W-1:0] cnt_o,
    output logic           pend_o
);
    logic [P_W-1:0] cnt_q;
    logic           pend_q;
    logic           wrap;

    // Detect the tick on which the count sits at the threshold.
    always_comb wrap = tick_i && (cnt_q == thr_i);

    // Count ticks, wrapping at the threshold; hold at zero while stopped.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt_q <= '0;
        else if (!run_i) cnt_q <= '0;
        else if (wrap)   cnt_q <= '0;
        else if (tick_i) cnt_q <= cnt_q + P_W'(1);
    end

    // Keep the pending flag: a wrap sets it, a clear drops it, and a set wins.
    always_ff @(posedge clk) begin
        if (!rst_n)     pend_q <= 1'b0;
        else if (wrap)  pend_q <= 1'b1;
        else if (clr_i) pend_q <= 1'b0;
    end

    assign cnt_o  = cnt_q;
    assign pend_o = pend_q;

    // R2: a stopped timer shows a zero count one cycle later.
    assert_stopped_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> (cnt_q == '0));
    // R4: without a tick the count either holds or has been reset to zero.
    assert_hold_between_ticks_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |=> (cnt_q == $past(cnt_q) || cnt_q == '0));
    // R5: a tick at the threshold raises the pending flag.
    assert_wrap_sets_pending_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && cnt_q == thr_i) |=> pend_q);
    // R6: a clear with no wrap on the same edge drops the flag.
    assert_clear_drops_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !(tick_i && cnt_q == thr_i)) |=> !pend_q);
    // R7: a clear together with a wrap leaves the flag set.
    assert_set_beats_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && tick_i && cnt_q == thr_i) |=> pend_q);
endmodule

// File: rtl/match_timer_regs.sv
// Module: register decode for match_timer: control and threshold storage, the
// self-clearing clear action and the combinational read path.
// Assumes: byte offsets; unmapped or unaligned offsets read 0 and ignore writes.
module match_timer_regs
    import match_timer_pkg::*;
#(
    parameter int unsigned P_W      = TMR_W,
    parameter int unsigned P_ADDR_W = 4,
    parameter int unsigned P_SEL_W  = SEL_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_i,
    input  logic                rd_i,
    input  logic [P_ADDR_W-1:0] addr_i,
    input  logic [P_W-1:0]      wdata_i,
    input  logic [P_W-1:0]      cnt_i,
    input  logic                pend_i,
    output logic                run_o,
    output logic [P_SEL_W-1:0]  sel_o,
    output logic [P_W-1:0]      thr_o,
    output logic                clr_o,
    output logic [P_W-1:0]      rdata_o
);
    localparam int unsigned SEL_HI = BIT_SEL_LO + P_SEL_W - 1;

    logic                hit_ctrl, hit_thr, hit_cnt;
    logic                run_q;
    logic [P_SEL_W-1:0]  sel_q;
    logic [P_W-1:0]      thr_q;
    logic [P_W-1:0]      ctrl_view;

    // Decode the byte offset into register selects.
    always_comb begin
        hit_ctrl = (addr_i == P_ADDR_W'(OFS_CTRL));
        hit_thr  = (addr_i == P_ADDR_W'(OFS_THR));
        hit_cnt  = (addr_i == P_ADDR_W'(OFS_COUNT));
    end

    // Store the run bit and the divider selection from control writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 1'b0;
            sel_q <= '0;
        end else if (wr_i && hit_ctrl) begin
            run_q <= wdata_i[BIT_RUN];
            sel_q <= wdata_i[SEL_HI:BIT_SEL_LO];
        end
    end

    // Store the threshold from threshold writes.
    always_ff @(posedge clk) begin
        if (!rst_n)                thr_q <= '0;
        else if (wr_i && hit_thr)  thr_q <= wdata_i;
    end

    // Raise the clear action for the single cycle of a control write with the bit set.
    always_comb clr_o = wr_i && hit_ctrl && wdata_i[BIT_CLR];

    // Assemble the control view: flag on top, the action bit always 0.
    always_comb begin
        ctrl_view                     = '0;
        ctrl_view[BIT_PEND]           = pend_i;
        ctrl_view[SEL_HI:BIT_SEL_LO]  = sel_q;
        ctrl_view[BIT_RUN]            = run_q;
    end

    // Drive read data for the addressed register, zero otherwise.
    always_comb begin
        rdata_o = '0;
        if (rd_i) begin
            if (hit_ctrl)     rdata_o = ctrl_view;
            else if (hit_thr) rdata_o = thr_q;
            else if (hit_cnt) rdata_o = cnt_i;
        end
    end

    assign run_o = run_q;
    assign sel_o = sel_q;
    assign thr_o = thr_q;

    // R8: the threshold read in the cycle after a write equals the written word.
    assert_thr_readback_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && hit_thr) |=> (thr_q == $past(wdata_i)));
endmodule

// File: rtl/match_timer.sv
// Module: top of the prescaled threshold timer. Ties the register block, the
// divider and the counter together; irq mirrors the pending flag.
// Assumes: single clock domain, synchronous active-low reset, one-cycle strobes.
module match_timer
    import match_timer_pkg::*;
#(
    parameter int unsigned DATA_W = TMR_W,
    parameter int unsigned ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    logic              run;
    logic [SEL_W-1:0]  sel;
    logic [DATA_W-1:0] thr;
    logic              clr;
    logic              tick;
    logic [DATA_W-1:0] cnt;
    logic              pend;

    match_timer_regs #(
        .P_W      (DATA_W),
        .P_ADDR_W (ADDR_W),
        .P_SEL_W  (SEL_W)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (bus_wr),
        .rd_i    (bus_rd),
        .addr_i  (bus_addr),
        .wdata_i (bus_wdata),
        .cnt_i   (cnt),
        .pend_i  (pend),
        .run_o   (run),
        .sel_o   (sel),
        .thr_o   (thr),
        .clr_o   (clr),
        .rdata_o (bus_rdata)
    );

    match_timer_prescaler #(
        .P_SEL_W (SEL_W),
        .P_DIV_W (DIV_W)
    ) u_prescaler (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (run),
        .sel_i  (sel),
        .tick_o (tick)
    );

    match_timer_counter #(
        .P_W (DATA_W)
    ) u_counter (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (run),
        .tick_i (tick),
        .thr_i  (thr),
        .clr_i  (clr),
        .cnt_o  (cnt),
        .pend_o (pend)
    );

    assign irq = pend;

    // R8: a write to the count offset while running leaves the count alone when no tick lands.
    assert_count_write_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(OFS_COUNT) && run && !tick) |=> (cnt == $past(cnt)));
    // R1: the cycle after reset shows an idle timer with no interrupt.
    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> (!irq && cnt == '0));
endmodule

// File: tb/match_timer_bench.sv
module match_timer_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;
    localparam logic [3:0] A_CTRL = 4'h0;
    localparam logic [3:0] A_THR  = 4'h4;
    localparam logic [3:0] A_CNT  = 4'h8;
    localparam logic [31:0] CLR_BIT = 32'h4000_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int n_cmp = 0;
    int n_bad = 0;
    int cycles = 0;

    match_timer u_match_timer (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int ratio_of(input int sel);
        case (sel)
            0: return 2;     1: return 4;     2: return 8;     3: return 64;
            4: return 128;   5: return 1024;  6: return 2048;  default: return 4096;
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // Caller sits at a falling edge; the write lands on the next rising edge.
    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic peek(input logic [3:0] a, output logic [31:0] v);
        bus_rd = 1'b1; bus_addr = a;
        #1;
        v = bus_rdata;
        bus_rd = 1'b0;
    endtask

    task automatic stop_and_clear();
        wr(A_CTRL, 32'h0);
        wr(A_CTRL, CLR_BIT);
    endtask

    // Run a full sweep: enable with sel and threshold thr, compare every cycle.
    task automatic sweep(input int sel, input int thr);
        int r;
        logic [31:0] v;
        r = ratio_of(sel);
        stop_and_clear();
        wr(A_THR, 32'(thr));
        wr(A_CTRL, 32'((sel << 1) | 1));
        for (int m = 0; m <= r * (thr + 1) + r; m++) begin
            peek(A_CNT, v);
            check("R3 R4 count", v, 32'((m / r) % (thr + 1)));
            check("R5 irq", {31'b0, irq}, {31'b0, (m >= r * (thr + 1))});
            @(negedge clk);
        end
        peek(A_CTRL, v);
        check("R5 R8 ctrl view", v, 32'h8000_0000 | 32'((sel << 1) | 1));
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > WATCHDOG) begin
                n_cmp++; n_bad++;
                $display("FAIL watchdog: got %0d cycles expected under %0d", cycles, WATCHDOG);
                finish_run();
            end
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        peek(A_CTRL, v); check("R1 ctrl", v, 32'h0);
        peek(A_THR, v);  check("R1 thr", v, 32'h0);
        peek(A_CNT, v);  check("R1 count", v, 32'h0);
        check("R1 irq", {31'b0, irq}, 32'h0);

        // R8: register readback and ignored / unmapped accesses
        wr(A_THR, 32'hFFFF_FFFF);
        peek(A_THR, v); check("R8 thr max", v, 32'hFFFF_FFFF);
        wr(A_CTRL, 32'h0000_000E);
        peek(A_CTRL, v); check("R8 ctrl sel", v, 32'h0000_000E);
        peek(4'hC, v); check("R8 unmapped", v, 32'h0);
        wr(A_CTRL, 32'h0000_000F);
        repeat (5) @(negedge clk);
        wr(A_CNT, 32'h0000_0055);
        peek(A_CNT, v); check("R8 count write ignored", v, 32'h0);

        // R2: idle count never moves
        stop_and_clear();
        wr(A_THR, 32'd3);
        repeat (20) @(negedge clk);
        peek(A_CNT, v); check("R2 stopped", v, 32'h0);

        // R3: every divide setting
        for (int s = 0; s < 8; s++) sweep(s, 2);
        // R4 R9: many thresholds at /2, threshold 0 included
        for (int t = 0; t <= 5; t++) sweep(0, t);

        // R2: stop mid-run, then restart from zero at a new ratio
        stop_and_clear();
        wr(A_THR, 32'd10);
        wr(A_CTRL, 32'h1);
        repeat (9) @(negedge clk);
        peek(A_CNT, v); check("R2 running", v, 32'd4);
        wr(A_CTRL, 32'h0);
        @(negedge clk);
        peek(A_CNT, v); check("R2 stop zero", v, 32'h0);
        repeat (6) @(negedge clk);
        peek(A_CNT, v); check("R2 stays zero", v, 32'h0);
        wr(A_CTRL, 32'h3);
        repeat (3) @(negedge clk);
        peek(A_CNT, v); check("R2 restart phase", v, 32'h0);
        @(negedge clk);
        peek(A_CNT, v); check("R2 first step", v, 32'h1);

        // R6 R7: clear against a wrap on the same edge
        stop_and_clear();
        wr(A_THR, 32'd1);
        wr(A_CTRL, 32'h1);
        repeat (5) @(negedge clk);             // m = 5, first wrap at m = 4
        check("R5 first wrap", {31'b0, irq}, 32'h1);
        wr(A_CTRL, 32'h1);                     // m = 6, bit 30 low
        check("R6 no clear", {31'b0, irq}, 32'h1);
        wr(A_CTRL, 32'h1 | CLR_BIT);           // edge m = 7, no wrap
        check("R6 clear", {31'b0, irq}, 32'h0);
        peek(A_CTRL, v); check("R6 action bit reads 0", v, 32'h1);
        wr(A_CTRL, 32'h1 | CLR_BIT);           // edge m = 8 is the second wrap
        check("R7 set wins", {31'b0, irq}, 32'h1);
        peek(A_CTRL, v); check("R7 ctrl", v, 32'h8000_0001);
        peek(A_CNT, v); check("R7 count wrapped", v, 32'h0);

        finish_run();
    end
endmodule